// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block finds where one instruction ends in a byte stream whose instructions have variable length. Each request carries a 16-byte fetch window and a start offset inside it, for example the byte a branch lands on. The block returns the length of the instruction that begins at the offset, the offset where the next instruction begins, and three flags. It recognises segment, lock, repeat, operand-size and address-size prefixes, the 0x0F escape to a second opcode map, the register/memory operand byte, the scaled-index byte, displacements and immediates.

The bytes are not walked one at a time. The candidate bytes after the start offset are each turned into a 256-way one-hot vector and reduced to a few class signals. One layout hypothesis per possible prefix count is evaluated in parallel, and the number of leading prefix bytes selects one of them. The result must always equal what a byte-by-byte parse of the same bytes gives. Opcode validity is not checked. Odd encodings that still have a plausible length pass through with an unsupported flag raised.

Requests enter through a valid/ready port and results leave through a valid/ready port, with one output register between them. A request is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A result stays on the outputs, unchanged, until `out_ready` takes it. The sender must hold `in_valid` and its data until the request is taken.

Top module: `vlen_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. A request taken in one cycle shows its result with `out_valid` high from the next clock edge on.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every result output hold their values.
- R3: These bytes are prefixes: 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2, 0xF3. Up to MAX_PFX leading prefixes are absorbed into the length. If MAX_PFX+1 leading bytes are all prefixes, the length is MAX_PFX+1 and `out_unsup` is set.
- R4: One-byte opcode classes. For 0x00–0x3F, low 3 bits 0–3 take a register/memory operand byte (RM), 4 takes imm8, 5 takes a full immediate, and 6–7 take nothing.
  - RM only: 62, 63, 84–8F, C4, C5, D0–D3, D8–DF, FE, FF.
  - RM+imm8: 6B, 80, 82, 83, C0, C1, C6.
  - RM+full: 69, 81, C7.
  - imm8: 6A, 70–7F, A8, B0–B7, CD, D4, D5, E0–E7, EB.
  - Full immediate: 68, A9, B8–BF, E8, E9.
  - imm16: C2, CA. 3 bytes: C8. Fixed 4-byte address: A0–A3.
  - Everything else is the opcode byte alone.
- R5: 0x0F escapes to a second opcode byte. Second bytes 0x80–0x8F take a full immediate and no RM byte. All other second bytes take an RM byte and no immediate. Second bytes 0x38 and 0x3A also set `out_unsup`.
- R6: The RM byte is split as mode[7:6], reg[5:3], rm[2:0].
  - mode≠3 with rm=4 adds a scaled-index byte.
  - mode=1 adds 1 displacement byte and mode=2 adds 4.
  - mode=0 adds 4 when rm=5, or when a scaled-index byte is present and its bits [2:0] are 5.
  - mode=3 adds nothing.
- R7: A full immediate is 4 bytes, or 2 bytes if any absorbed prefix is 0x66. The imm8, imm16, 3-byte and fixed 4-byte sizes ignore 0x66.
- R8: F6 takes imm8 and F7 takes a full immediate only when RM reg=0. Otherwise they take no immediate.
- R9: `out_next` equals `in_start` plus `out_len`. Bytes before the start offset have no effect.
- R10: If `in_start` plus the computed length exceeds 16, `out_more` is 1 and `out_len`, `out_next`, `out_toolong` and `out_unsup` are all 0.
- R11: `out_toolong` is 1 exactly when the reported length exceeds MAX_LEN, which is 15 by default.
- R12: `out_unsup` is set for opcode bytes 82, 9A, D6, EA and F1, for 0F 38 and 0F 3A, and for the prefix overflow of R3. The length is still reported.
- R13: For any window and start offset, every output matches a sequential byte-at-a-time parse of the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_window | input | 128 | Fetch window, byte i at bits [8i+7:8i] |
| in_start | input | 4 | Offset of the first instruction byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 5 | Instruction length in bytes |
| out_next | output | 5 | Offset of the following instruction |
| out_more | output | 1 | Instruction runs past the window |
| out_toolong | output | 1 | Length above the architectural limit |
| out_unsup | output | 1 | Encoding outside the supported set |

## Verification
The bench builds the decoder with MAX_PFX set to 5 instead of 4. Six prefix hypotheses are then in play, and a five-prefix instruction with RM, scaled-index byte, 32-bit displacement and 32-bit immediate reaches 16 bytes. That makes the too-long flag reachable inside one window. It also moves the prefix-overflow case to six leading prefixes. Random start offsets near the end of the window exercise the need-more-bytes path. A byte pool biased toward prefixes, escapes and RM/scaled-index patterns pushes the random windows into the multi-hypothesis selections.

// File: rtl/vlen_pkg.sv
`timescale 1ns/1ps
package vlen_pkg;

  typedef enum logic [2:0] {
    IMM_NONE = 3'd0,
    IMM_B1   = 3'd1,
    IMM_W2   = 3'd2,
    IMM_W3   = 3'd3,
    IMM_FULL = 3'd4,
    IMM_F4   = 3'd5
  } imm_e;

  typedef struct packed {
    logic modrm;
    imm_e imm;
    logic grp3;
    logic unsup;
  } opc_info_t;

  function automatic logic is_prefix_byte(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                     8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  function automatic logic [255:0] prefix_mask();
    logic [255:0] m;
    m = '0;
    for (int i = 0; i < 256; i++) m[i] = is_prefix_byte(8'(i));
    return m;
  endfunction

  function automatic opc_info_t one_byte_info(input logic [7:0] b);
    opc_info_t r;
    r = '{modrm: 1'b0, imm: IMM_NONE, grp3: 1'b0, unsup: 1'b0};
    if (b < 8'h40) begin
      case (b[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: r.modrm = 1'b1;
        3'd4:                   r.imm = IMM_B1;
        3'd5:                   r.imm = IMM_FULL;
        default:                r.imm = IMM_NONE;
      endcase
    end else begin
      casez (b)
        8'h62, 8'h63, 8'hC4, 8'hC5, 8'hFE, 8'hFF,
        8'b1000_01??, 8'b1000_1???, 8'b1101_00??, 8'b1101_1???:
          r.modrm = 1'b1;
        8'h6B, 8'h80, 8'h83, 8'hC0, 8'hC1, 8'hC6: begin
          r.modrm = 1'b1; r.imm = IMM_B1;
        end
        8'h82: begin
          r.modrm = 1'b1; r.imm = IMM_B1; r.unsup = 1'b1;
        end
        8'h69, 8'h81, 8'hC7: begin
          r.modrm = 1'b1; r.imm = IMM_FULL;
        end
        8'h6A, 8'b0111_????, 8'hA8, 8'b1011_0???, 8'hCD,
        8'hD4, 8'hD5, 8'b1110_0???, 8'hEB:
          r.imm = IMM_B1;
        8'h68, 8'hA9, 8'b1011_1???, 8'hE8, 8'hE9:
          r.imm = IMM_FULL;
        8'hC2, 8'hCA: r.imm = IMM_W2;
        8'hC8:        r.imm = IMM_W3;
        8'b1010_00??: r.imm = IMM_F4;
        8'hF6: begin
          r.modrm = 1'b1; r.imm = IMM_B1; r.grp3 = 1'b1;
        end
        8'hF7: begin
          r.modrm = 1'b1; r.imm = IMM_FULL; r.grp3 = 1'b1;
        end
        8'h9A, 8'hD6, 8'hEA, 8'hF1: r.unsup = 1'b1;
        default: r.imm = IMM_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic opc_info_t two_byte_info(input logic [7:0] b);
    opc_info_t r;
    r = '{modrm: 1'b0, imm: IMM_NONE, grp3: 1'b0, unsup: 1'b0};
    if (b[7:4] == 4'h8) r.imm = IMM_FULL;
    else r.modrm = 1'b1;
    r.unsup = (b == 8'h38) || (b == 8'h3A);
    return r;
  endfunction

  function automatic logic [2:0] imm_bytes(input imm_e k, input logic short_op);
    case (k)
      IMM_B1:   return 3'd1;
      IMM_W2:   return 3'd2;
      IMM_W3:   return 3'd3;
      IMM_FULL: return short_op ? 3'd2 : 3'd4;
      IMM_F4:   return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/vlen_predecode.sv
`timescale 1ns/1ps
module vlen_predecode
  import vlen_pkg::*;
#(
  parameter int NC = 5
) (
  input  logic [NC*8-1:0] cand_bytes,
  output logic [NC-1:0]   is_pfx,
  output logic [NC-1:0]   is_opsz
);
  localparam logic [255:0] PMASK = prefix_mask();

  for (genvar g = 0; g < NC; g++) begin : g_byte
    logic [255:0] onehot;
    assign onehot     = 256'd1 << cand_bytes[8*g +: 8];
    assign is_pfx[g]  = |(onehot & PMASK);
    assign is_opsz[g] = onehot[8'h66];
  end
endmodule

// File: rtl/vlen_hyp.sv
`timescale 1ns/1ps
module vlen_hyp
  import vlen_pkg::*;
#(
  parameter int NB = 16,
  parameter int K  = 0,
  parameter int LW = 5
) (
  input  logic [NB*8-1:0] sh,
  input  logic            short_op,
  output logic [LW-1:0]   len,
  output logic            unsup
);
  logic [7:0] op, op2, rmb, sibb;
  logic       esc, has_sib;
  opc_info_t  inf;
  logic [2:0] dsz, isz;

  always_comb begin
    op   = sh[8*K +: 8];
    op2  = sh[8*(K+1) +: 8];
    esc  = (op == 8'h0F);
    inf  = esc ? two_byte_info(op2) : one_byte_info(op);
    rmb  = esc ? sh[8*(K+2) +: 8] : sh[8*(K+1) +: 8];
    sibb = esc ? sh[8*(K+3) +: 8] : sh[8*(K+2) +: 8];
    has_sib = inf.modrm && (rmb[7:6] != 2'b11) && (rmb[2:0] == 3'b100);
    dsz = 3'd0;
    if (inf.modrm) begin
      case (rmb[7:6])
        2'b00: if (rmb[2:0] == 3'b101 || (has_sib && sibb[2:0] == 3'b101)) dsz = 3'd4;
        2'b01: dsz = 3'd1;
        2'b10: dsz = 3'd4;
        default: dsz = 3'd0;
      endcase
    end
    isz = imm_bytes(inf.imm, short_op);
    if (inf.grp3 && rmb[5:3] != 3'b000) isz = 3'd0;
    len = LW'(K + 1) + LW'(esc) + LW'(inf.modrm) + LW'(has_sib) + LW'(dsz) + LW'(isz);
    unsup = inf.unsup;
  end
endmodule

// File: rtl/vlen_core.sv
`timescale 1ns/1ps
module vlen_core #(
  parameter int NB     = 16,
  parameter int MAXP   = 4,
  parameter int MAXLEN = 15,
  parameter int SW     = 4,
  parameter int LW     = 5
) (
  input  logic [NB*8-1:0] win,
  input  logic [SW-1:0]   start,
  output logic [LW-1:0]   len,
  output logic [LW-1:0]   nxt,
  output logic            more,
  output logic            toolong,
  output logic            unsup
);
  localparam int NC = MAXP + 1;
  localparam int CW = $clog2(NC + 1);

  logic [NB*8-1:0] sh;
  logic [NC-1:0]   pfx, opsz;
  logic [NC:0]     cum_opsz;
  logic [LW-1:0]   hlen [NC];
  logic [NC-1:0]   hun;
  logic [CW-1:0]   npf;
  logic            run;
  logic [LW-1:0]   sel_len;
  logic            sel_un;
  logic [LW:0]     endp;

  // Align the window so the start byte sits at position 0; bytes past the end read as zero.
  always_comb begin
    for (int i = 0; i < NB; i++) begin
      logic [SW:0] idx;
      idx = (SW+1)'(start) + (SW+1)'(i);
      sh[8*i +: 8] = (idx < (SW+1)'(NB)) ? win[8*idx[SW-1:0] +: 8] : 8'h00;
    end
  end

  vlen_predecode #(.NC(NC)) u_pre (
    .cand_bytes(sh[NC*8-1:0]),
    .is_pfx    (pfx),
    .is_opsz   (opsz)
  );

  assign cum_opsz[0] = 1'b0;
  for (genvar k = 0; k < NC; k++) begin : g_hyp
    assign cum_opsz[k+1] = cum_opsz[k] | opsz[k];
    vlen_hyp #(.NB(NB), .K(k), .LW(LW)) u_hyp (
      .sh      (sh),
      .short_op(cum_opsz[k]),
      .len     (hlen[k]),
      .unsup   (hun[k])
    );
  end

  // Leading prefix count picks the hypothesis.
  always_comb begin
    npf = '0;
    run = 1'b1;
    for (int i = 0; i < NC; i++) begin
      if (run && pfx[i]) npf = npf + 1'b1;
      else run = 1'b0;
    end
    sel_len = LW'(NC);
    sel_un  = 1'b1;
    for (int k = 0; k < NC; k++) begin
      if (npf == CW'(k)) begin
        sel_len = hlen[k];
        sel_un  = hun[k];
      end
    end
    endp = (LW+1)'(start) + (LW+1)'(sel_len);
    more = endp > (LW+1)'(NB);
    if (more) begin
      len = '0; nxt = '0; toolong = 1'b0; unsup = 1'b0;
    end else begin
      len     = sel_len;
      nxt     = endp[LW-1:0];
      toolong = sel_len > LW'(MAXLEN);
      unsup   = sel_un;
    end
  end
endmodule

// File: rtl/vlen_decoder.sv
`timescale 1ns/1ps
module vlen_decoder #(
  parameter  int NB      = 16,
  parameter  int MAX_PFX = 4,
  parameter  int MAX_LEN = 15,
  localparam int SW      = $clog2(NB),
  localparam int MAXL    = MAX_PFX + 12,
  localparam int LW      = $clog2(((NB > MAXL) ? NB : MAXL) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NB*8-1:0] in_window,
  input  logic [SW-1:0]   in_start,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [LW-1:0]   out_len,
  output logic [LW-1:0]   out_next,
  output logic            out_more,
  output logic            out_toolong,
  output logic            out_unsup
);
  logic [LW-1:0] c_len, c_nxt;
  logic          c_more, c_tl, c_un;
  logic          take;

  vlen_core #(.NB(NB), .MAXP(MAX_PFX), .MAXLEN(MAX_LEN), .SW(SW), .LW(LW)) u_core (
    .win    (in_window),
    .start  (in_start),
    .len    (c_len),
    .nxt    (c_nxt),
    .more   (c_more),
    .toolong(c_tl),
    .unsup  (c_un)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_len     <= '0;
      out_next    <= '0;
      out_more    <= 1'b0;
      out_toolong <= 1'b0;
      out_unsup   <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_len     <= c_len;
      out_next    <= c_nxt;
      out_more    <= c_more;
      out_toolong <= c_tl;
      out_unsup   <= c_un;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_take_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_next)
      && $stable(out_more) && $stable(out_toolong) && $stable(out_unsup)));
  p_next_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_more) |-> (out_next <= LW'(NB) && out_next >= out_len && out_len != '0));
  p_more_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_more) |-> (out_len == '0 && out_next == '0 && !out_toolong && !out_unsup));
  p_toolong_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_toolong) |-> (out_len > LW'(MAX_LEN)));
endmodule

// File: tb/vlen_decoder_tb_top.sv
`timescale 1ns/1ps
module vlen_decoder_tb_top;
  localparam int NB   = 16;
  localparam int MAXP = 5;
  localparam int MAXL = 15;
  localparam int LW   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [NB*8-1:0] in_window = '0;
  logic [3:0] in_start = '0;
  logic [LW-1:0] out_len, out_next;
  logic out_more, out_toolong, out_unsup;

  int n_tests = 0, n_fail = 0;

  typedef struct {
    int len; int nxt; bit more; bit tl; bit un; string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  vlen_decoder #(.NB(NB), .MAX_PFX(MAXP), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_window(in_window), .in_start(in_start), .out_valid(out_valid),
    .out_ready(out_ready), .out_len(out_len), .out_next(out_next),
    .out_more(out_more), .out_toolong(out_toolong), .out_unsup(out_unsup));

  function automatic logic [7:0] gb(input logic [NB*8-1:0] w, input int p);
    return (p < NB) ? w[8*p +: 8] : 8'h00;
  endfunction

  // Sequential byte-at-a-time reference parse.
  function automatic exp_t ref_parse(input logic [NB*8-1:0] w, input int s, input string tag);
    exp_t e;
    int pos, np, isz, disp;
    bit o16, rm_on, grp, un;
    logic [7:0] op, op2, rm, sib;
    pos = s; np = 0; o16 = 0; rm_on = 0; grp = 0; un = 0; isz = 0;
    while (np < MAXP + 1 && (gb(w, pos) inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64,
           8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3})) begin
      if (gb(w, pos) == 8'h66) o16 = 1;
      np++; pos++;
    end
    if (np == MAXP + 1) un = 1;
    else begin
      op = gb(w, pos); pos++;
      if (op == 8'h0F) begin
        op2 = gb(w, pos); pos++;
        if (op2 >= 8'h80 && op2 <= 8'h8F) isz = o16 ? 2 : 4;
        else rm_on = 1;
        if (op2 == 8'h38 || op2 == 8'h3A) un = 1;
      end else begin
        if (op < 8'h40) begin
          if (op[2:0] < 3'd4) rm_on = 1;
          else if (op[2:0] == 3'd4) isz = 1;
          else if (op[2:0] == 3'd5) isz = o16 ? 2 : 4;
        end else if (op inside {8'h62, 8'h63, [8'h84:8'h8F], 8'hC4, 8'hC5,
                                [8'hD0:8'hD3], [8'hD8:8'hDF], 8'hFE, 8'hFF}) rm_on = 1;
        else if (op inside {8'h6B, 8'h80, 8'h82, 8'h83, 8'hC0, 8'hC1, 8'hC6}) begin
          rm_on = 1; isz = 1;
        end else if (op inside {8'h69, 8'h81, 8'hC7}) begin
          rm_on = 1; isz = o16 ? 2 : 4;
        end else if (op inside {8'h6A, [8'h70:8'h7F], 8'hA8, [8'hB0:8'hB7], 8'hCD,
                                8'hD4, 8'hD5, [8'hE0:8'hE7], 8'hEB}) isz = 1;
        else if (op inside {8'h68, 8'hA9, [8'hB8:8'hBF], 8'hE8, 8'hE9}) isz = o16 ? 2 : 4;
        else if (op inside {8'hC2, 8'hCA}) isz = 2;
        else if (op == 8'hC8) isz = 3;
        else if (op inside {[8'hA0:8'hA3]}) isz = 4;
        else if (op == 8'hF6) begin rm_on = 1; grp = 1; isz = 1; end
        else if (op == 8'hF7) begin rm_on = 1; grp = 1; isz = o16 ? 2 : 4; end
        if (op inside {8'h82, 8'h9A, 8'hD6, 8'hEA, 8'hF1}) un = 1;
      end
      if (rm_on) begin
        rm = gb(w, pos); pos++;
        disp = 0;
        if (rm[7:6] != 2'b11 && rm[2:0] == 3'b100) begin
          sib = gb(w, pos); pos++;
          if (rm[7:6] == 2'b00 && sib[2:0] == 3'b101) disp = 4;
        end
        if (rm[7:6] == 2'b00 && rm[2:0] == 3'b101) disp = 4;
        if (rm[7:6] == 2'b01) disp = 1;
        if (rm[7:6] == 2'b10) disp = 4;
        pos += disp;
        if (grp && rm[5:3] != 3'b000) isz = 0;
      end
      pos += isz;
    end
    e.tag = tag;
    if (pos > NB) begin
      e.len = 0; e.nxt = 0; e.more = 1; e.tl = 0; e.un = 0;
    end else begin
      e.len = pos - s; e.nxt = pos; e.more = 0; e.tl = (pos - s) > MAXL; e.un = un;
    end
    return e;
  endfunction

  // Driver: holds the request until taken, then pushes the expected result.
  task automatic send(input string tag, input int s, input logic [NB*8-1:0] w);
    @(negedge clk); #1;
    in_valid = 1; in_window = w; in_start = 4'(s);
    forever begin
      #8;
      if (in_ready) begin
        sb_q.push_back(ref_parse(w, s, tag));
        break;
      end
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    in_valid = 0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  // Places n bytes (first byte most significant in seq) at offset s; the rest is random filler.
  task automatic send_seq(input string tag, input int s, input logic [127:0] seq, input int n);
    logic [NB*8-1:0] w;
    for (int i = 0; i < NB; i++) w[8*i +: 8] = 8'($urandom);
    for (int j = 0; j < n; j++) if (s + j < NB) w[8*(s+j) +: 8] = seq[8*(n-1-j) +: 8];
    send(tag, s, w);
  endtask

  // Monitor: pops expected results as the design hands them over.
  initial begin
    bit stall_pend = 0;
    int s_len = 0, s_nxt = 0;
    bit s_more = 0, s_tl = 0, s_un = 0;
    forever begin
      @(negedge clk); #2;
      out_ready = ($urandom_range(0, 9) < 7);
      #6;
      if (stall_pend) begin
        n_tests++;
        if (!out_valid || out_len != s_len || out_next != s_nxt || out_more != s_more
            || out_toolong != s_tl || out_unsup != s_un) begin
          n_fail++;
          $display("FAIL R2: held result changed v=%0b len=%0d next=%0d, expected v=1 len=%0d next=%0d",
                   out_valid, out_len, out_next, s_len, s_nxt);
        end
        stall_pend = 0;
      end
      if (out_valid && out_ready) begin
        exp_t e;
        n_tests++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1: result with no request pending, actual len=%0d, expected none", out_len);
        end else begin
          e = sb_q.pop_front();
          if (out_len != e.len || out_next != e.nxt || out_more != e.more
              || out_toolong != e.tl || out_unsup != e.un) begin
            n_fail++;
            $display("FAIL %s: actual len=%0d next=%0d more=%0b tl=%0b un=%0b expected len=%0d next=%0d more=%0b tl=%0b un=%0b",
                     e.tag, out_len, out_next, out_more, out_toolong, out_unsup,
                     e.len, e.nxt, e.more, e.tl, e.un);
          end
        end
      end else if (out_valid) begin
        stall_pend = 1;
        s_len = out_len; s_nxt = out_next; s_more = out_more; s_tl = out_toolong; s_un = out_unsup;
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pool [16] = '{8'h66, 8'hF0, 8'h2E, 8'h0F, 8'h8B, 8'h81, 8'hF7, 8'h05,
                              8'hC8, 8'hA1, 8'h80, 8'h84, 8'h24, 8'h44, 8'h04, 8'hB8};
    repeat (5) @(negedge clk);
    #8;
    n_tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: reset state out_valid=%0b in_ready=%0b, expected 0 and 1", out_valid, in_ready);
    end
    @(negedge clk); rst_n = 1;

    send_seq("R4", 0, 128'h90, 1);
    send_seq("R4", 0, 128'h05_11223344, 5);
    send_seq("R4", 2, 128'hC8_112233, 4);
    send_seq("R4", 0, 128'hC2_1122, 3);
    send_seq("R4", 0, 128'h6B_C0_11, 3);
    send_seq("R3", 0, 128'h66_66_F0_2E_90, 5);
    send_seq("R3", 0, 128'h67_F3_A4, 3);
    send_seq("R3", 0, 128'h66_66_F0_2E_3E_64_90, 7);
    send_seq("R7", 0, 128'h66_05_1122, 4);
    send_seq("R7", 0, 128'h66_A1_11223344, 6);
    send_seq("R7", 0, 128'h66_6A_11, 3);
    send_seq("R6", 0, 128'h8B_04_25_11223344, 7);
    send_seq("R6", 0, 128'h8B_45_11, 3);
    send_seq("R6", 0, 128'h8B_80_11223344, 6);
    send_seq("R6", 0, 128'h8B_05_11223344, 6);
    send_seq("R6", 0, 128'h8B_C0, 2);
    send_seq("R6", 0, 128'h8B_44_24_11, 4);
    send_seq("R5", 0, 128'h0F_84_11223344, 6);
    send_seq("R5", 0, 128'h0F_AF_C0, 3);
    send_seq("R5", 0, 128'h66_0F_85_1122, 5);
    send_seq("R8", 0, 128'hF6_C0_11, 3);
    send_seq("R8", 0, 128'hF6_D0, 2);
    send_seq("R8", 0, 128'hF7_C0_11223344, 6);
    send_seq("R8", 0, 128'h66_F7_C0_1122, 5);
    send_seq("R9", 10, 128'h90, 1);
    send_seq("R9", 7, 128'h81_C0_11223344, 6);
    send_seq("R10", 14, 128'hB8_11223344, 5);
    send_seq("R10", 15, 128'h0F_84_11223344, 6);
    send_seq("R11", 0, 128'hF0_2E_3E_64_65_81_84_24_11223344_55667788, 16);
    send_seq("R11", 1, 128'hF0_2E_3E_64_81_84_24_11223344_55667788, 15);
    send_seq("R12", 0, 128'h82_C0_11, 3);
    send_seq("R12", 0, 128'h0F_38_C0, 3);
    send_seq("R12", 3, 128'hF1, 1);

    for (int t = 0; t < 400; t++) begin
      logic [NB*8-1:0] w;
      for (int i = 0; i < NB; i++)
        w[8*i +: 8] = ($urandom_range(0, 1) == 1) ? pool[$urandom_range(0, 15)] : 8'($urandom);
      send("R13", $urandom_range(0, NB - 1), w);
    end

    for (int k = 0; k < 2000 && sb_q.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results never delivered, expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule